// File: doc/BRIEF.md
# Dual-Mode 16-bit DAC Modulator

The block drives a coarse 8-bit monotonic DAC from a 16-bit sample. The sample's upper byte is the base level N, and its lower byte L sets how often the next level N+1 is used in place of N. The averaged output therefore gains about eight bits of resolution beyond what the DAC alone provides. A new 8-bit code is produced on every clock.

Two ways of spreading the N+1 clocks are offered. In PWM mode the N+1 clocks sit together at the start of a fixed 256-clock frame, so the output changes level only twice per frame. A sample written to this mode is held in a buffer and is only adopted at the next frame boundary. In dither mode each clock chooses between N and N+1 by comparing L with a pseudo-random byte, and a new sample acts on the very next clock.

A third mode puts out a full-scale pseudo-random code on every clock, for use as a noise source. All pseudo-random bits come from a 32-bit LFSR. Each instance reads that LFSR through its own rotation and inversion of the taps. A strobe marks the end of each PWM frame, so software can time its sample updates.

Top module: `dac16_modulator`

## Requirements
- R1: In PWM mode (mode = 2'b00), with active sample {N, L} and N < 255, the code is N+1 on exactly L clocks of each 256-clock frame and N on the rest.
- R2: In PWM mode the N+1 clocks are the first L clocks of a frame (frame counts 0..L-1), so the code changes level at most twice per frame.
- R3: In PWM mode a written sample is adopted only at a frame boundary. At that boundary the active sample takes the value the buffer held before the boundary edge. A write on a frame's last clock therefore waits for the following boundary.
- R4: In PWM mode frame_done is high for exactly one clock per frame, in the same cycle as the frame's last code (count 255). It is low in the other modes and while disabled.
- R5: In dither mode (mode = 2'b01) the code is N+1 when L is strictly greater than the current pseudo-random byte, and N otherwise. L = 0 therefore always gives N.
- R6: In dither mode a sample written on one clock edge sets the code produced at the next edge, with no frame alignment.
- R7: In noise mode (mode[1] = 1) the code is the pseudo-random byte, which changes on every enabled clock.
- R8: The LFSR shifts left on every enabled clock, and its new bit 0 is bit31 ^ bit21 ^ bit1 ^ bit0. It starts from the SEED parameter (default 32'h1D872B41). Bit i of the pseudo-random byte is LFSR bit (i + ROT) mod 32 XOR INV bit i (defaults ROT = 5, INV = 8'hA5).
- R9: When N is 255 the code stays at 255 and never wraps to 0, in both PWM and dither modes.
- R10: While en is low, dac_code is 0 and frame_done is 0. The frame counter is held at 0 and the LFSR at SEED, so the first enabled clock starts a frame at count 0. A sample written while disabled becomes active at once.
- R11: Mode 2'b11 behaves exactly like noise mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the modulator idle |
| mode | input | 2 | 00 PWM, 01 dither, 1x noise |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample: upper byte level, lower byte fraction |
| dac_code | output | 8 | Registered code for the coarse DAC |
| frame_done | output | 1 | One-clock pulse on the last clock of a PWM frame |

## Verification
The PWM frame boundary, where the buffered sample is copied into the active sample and frame_done pulses, can fall in the same cycle as a new sample write. The bench provokes this by writing on the exact clock whose frame count is 255. It then judges, clock by clock against a reference model, that the following frame still uses the value buffered before that edge, and that the written value only appears one boundary later. A second collision, a dither-mode write on every clock, is judged by checking that each code follows the sample written one edge earlier.

// File: rtl/dac16_modulator.sv
module dac16_modulator #(
  parameter int          ROT  = 5,
  parameter logic [7:0]  INV  = 8'hA5,
  parameter logic [31:0] SEED = 32'h1D87_2B41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  mode,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [7:0]  dac_code,
  output logic        frame_done
);
  localparam int LW = 32;
  localparam int CW = 8;
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic [LW-1:0] lfsr;
  logic [CW-1:0] cnt;
  logic [15:0]   pend, act;
  logic [7:0]    rnd, next_code;

  wire fb      = lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0];
  wire pwm_up  = cnt < act[7:0];
  wire dith_up = pend[7:0] > rnd;

  always_comb
    for (int i = 0; i < 8; i++) rnd[i] = lfsr[(i + ROT) % LW] ^ INV[i];

  function automatic logic [7:0] lift(input logic [7:0] base, input logic up);
    return (up && base != 8'hFF) ? base + 8'd1 : base;
  endfunction

  always_comb
    case (mode)
      2'b00:   next_code = lift(act[15:8], pwm_up);
      2'b01:   next_code = lift(pend[15:8], dith_up);
      default: next_code = rnd;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr       <= SEED;
      cnt        <= '0;
      pend       <= '0;
      act        <= '0;
      dac_code   <= '0;
      frame_done <= 1'b0;
    end else begin
      if (wr_en) pend <= wr_data;
      if (!en) begin
        lfsr       <= SEED;
        cnt        <= '0;
        dac_code   <= '0;
        frame_done <= 1'b0;
        act        <= wr_en ? wr_data : pend;
      end else begin
        lfsr       <= {lfsr[LW-2:0], fb};
        cnt        <= cnt + 1'b1;
        dac_code   <= next_code;
        frame_done <= (mode == 2'b00) && (cnt == LAST);
        if (cnt == LAST) act <= pend;
      end
    end
  end
endmodule

// File: rtl/dac16_modulator_chk.sv
module dac16_modulator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [1:0]  mode,
  input logic [7:0]  dac_code,
  input logic        frame_done,
  input logic [7:0]  cnt,
  input logic [15:0] act,
  input logic [15:0] pend,
  input logic [7:0]  rnd
);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dac_code == 8'd0 && !frame_done));

  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != 8'hFF) |=> $stable(act));

  a_r5_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b01 && pend[7:0] == 8'd0) |=> dac_code == $past(pend[15:8]));

  a_r7_noise_code: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode[1]) |=> dac_code == $past(rnd));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b01 && pend[15:8] == 8'hFF) |=> dac_code == 8'hFF);

  a_r1_pwm_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && act[15:8] != 8'hFF) |=>
      (dac_code == $past(act[15:8]) || dac_code == $past(act[15:8]) + 8'd1));
endmodule

bind dac16_modulator dac16_modulator_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .dac_code(dac_code),
  .frame_done(frame_done), .cnt(cnt), .act(act), .pend(pend), .rnd(rnd)
);

// File: tb/dac16_modulator_tb_top.sv
module dac16_modulator_tb_top;
  localparam int          ROT  = 5;
  localparam logic [7:0]  INV  = 8'hA5;
  localparam logic [31:0] SEED = 32'h1D87_2B41;

  logic clk = 0, rst_n = 0, en = 0, wr_en = 0;
  logic [1:0] mode = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] dac_code;
  logic frame_done;

  always #4 clk = ~clk;

  dac16_modulator #(.ROT(ROT), .INV(INV), .SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .wr_en(wr_en),
    .wr_data(wr_data), .dac_code(dac_code), .frame_done(frame_done));

  typedef struct { logic [7:0] code; logic done; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_lfsr = SEED;
  logic [7:0]  m_cnt = 0;
  logic [15:0] m_pend = 0, m_act = 0;
  bit prev_wr = 0;

  function automatic logic [7:0] rnd_of(input logic [31:0] s);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = s[(i + ROT) % 32] ^ INV[i];
    return r;
  endfunction

  function automatic logic [7:0] up1(input logic [7:0] b, input bit u);
    return (u && b != 8'hFF) ? b + 8'd1 : b;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  task automatic cyc(input logic e, input logic [1:0] m, input logic w, input logic [15:0] d);
    item_t it;
    logic [7:0] r;
    @(negedge clk);
    en = e; mode = m; wr_en = w; wr_data = d;
    r = rnd_of(m_lfsr);
    it.done = 0;
    if (!e) begin
      it.code = 0; it.tag = "R10";
    end else if (m == 2'b00) begin
      it.code = up1(m_act[15:8], m_cnt < m_act[7:0]);
      it.done = (m_cnt == 8'hFF);
      it.tag = (m_act[15:8] == 8'hFF) ? "R9" : (m_cnt == 0) ? "R3" : "R1 R2";
    end else if (m == 2'b01) begin
      it.code = up1(m_pend[15:8], m_pend[7:0] > r);
      it.tag = (m_pend[15:8] == 8'hFF) ? "R9" : prev_wr ? "R6" : "R5";
    end else begin
      it.code = r;
      it.tag = (m == 2'b11) ? "R11 R8" : "R7 R8";
    end
    q.push_back(it);
    @(posedge clk);
    if (!e) begin
      m_cnt = 0; m_lfsr = SEED; m_act = w ? d : m_pend;
    end else begin
      if (m_cnt == 8'hFF) m_act = m_pend;
      m_cnt = m_cnt + 1;
      m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
    end
    if (w) m_pend = d;
    prev_wr = w;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, dac_code, it.code);
      chk("R4", {7'd0, frame_done}, {7'd0, it.done});
    end
  end

  task automatic run(input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) cyc(1, m, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R10 reset", dac_code, 8'h00);
    chk("R4 reset", {7'd0, frame_done}, 8'h00);
    cyc(0, 2'b00, 1, 16'h4040);
    for (int i = 0; i < 5; i++) cyc(0, 2'b10, 0, 0);
    run(2'b00, 100);
    cyc(1, 2'b00, 1, 16'h20C0);
    run(2'b00, 154);
    cyc(1, 2'b00, 1, 16'h7F01);
    run(2'b00, 512);
    cyc(1, 2'b00, 1, 16'hFF80);
    run(2'b00, 300);
    cyc(1, 2'b01, 1, 16'h3000);
    run(2'b01, 40);
    cyc(1, 2'b01, 1, 16'h3080);
    run(2'b01, 300);
    cyc(1, 2'b01, 1, 16'h10FF);
    run(2'b01, 100);
    for (int i = 0; i < 60; i++) cyc(1, 2'b01, 1, 16'((i * 16'h0937) ^ 16'h5A5A));
    cyc(1, 2'b01, 1, 16'hFFFF);
    run(2'b01, 50);
    run(2'b10, 100);
    run(2'b11, 100);
    for (int i = 0; i < 4; i++) cyc(0, 2'b10, 1, 16'h0A33);
    run(2'b10, 20);
    for (int i = 0; i < 3; i++) cyc(0, 2'b00, 0, 0);
    run(2'b00, 600);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule